// File: doc/BRIEF.md
# Write-Allocate Decision Unit

This unit sits beside an L1 data cache and answers one question for every write that misses: should the line be allocated into the cache? No single policy bit makes the choice. The unit evaluates four independent cacheability hints and grants an allocation when at least one of them votes yes. The four hints are:

- a remembered page from the most recent completed line fill;
- a sector whose tag matches while the addressed line in that sector is invalid;
- a programmable upper address limit;
- an optional fixed 1 MB window at 15 MB to 16 MB.

The cache lookup logic presents each write miss on `wr_req` with its address and two status bits from the tag array. The fill sequencer reports each finished line fill on `fill_done`. The limit and window settings are loaded through a simple register write strobe. The unit answers one cycle after the request, with a single-cycle `alloc_valid` strobe and the decision on `alloc_take`.

Top module: `wa_decide_unit`

## Requirements
- R1: Reset is synchronous and active low. After reset, `alloc_valid` and `alloc_take` are 0. The stored fill page is invalid, the limit is 0 and the window enable is off, so a write whose sector status does not vote is refused.
- R2: Each cycle with `wr_req`=1 produces `alloc_valid`=1 in exactly the next cycle, and only then. `alloc_take` is 0 whenever `alloc_valid` is 0.
- R3: Every completed fill stores bits [31:12] (the 4 KB page) of `fill_addr`. A later write whose bits [31:12] equal the stored page is allocated. A write to a neighbouring page gets no vote from this hint.
- R4: A fill from a different page replaces the stored page. Writes to the old page then lose this vote.
- R5: When `fill_done` and `wr_req` fall in the same cycle, the page compare uses the page stored before that fill.
- R6: `sec_tag_hit`=1 with `line_valid`=0 allocates. `sec_tag_hit`=1 with `line_valid`=1 gives no vote. `sec_tag_hit`=0 gives no vote.
- R7: With a nonzero limit L (in 4 MB units), a write whose address is below L×4 MB is allocated, and a write at exactly L×4 MB is not. A limit of 0 disables this hint.
- R8: With the window enable set, writes from 0x00F00000 to 0x00FFFFFF are allocated. Addresses 0x00EFFFFF and 0x01000000, and the same window with any upper address bit set, are not. With the enable clear, the window gives no vote.
- R9: The decision is the OR of the four hints. It is 1 if any one hint or several hints vote, and 0 if none does.
- R10: A register write takes effect for requests in later cycles. A request in the same cycle as `cfg_we` is judged with the previous settings.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_req | input | 1 | A write miss is presented this cycle |
| wr_addr | input | 32 | Byte address of the write |
| sec_tag_hit | input | 1 | Write address matches the tag of a valid sector |
| line_valid | input | 1 | Addressed line inside that sector is valid |
| fill_done | input | 1 | A line fill completed this cycle |
| fill_addr | input | 32 | Address of the completed fill |
| cfg_we | input | 1 | Load the write-handling settings |
| cfg_limit | input | 7 | Allocate limit in 4 MB units, 0 = off |
| cfg_win_en | input | 1 | Enable the 15–16 MB window |
| alloc_valid | output | 1 | Decision strobe, one cycle after `wr_req` |
| alloc_take | output | 1 | 1 = perform a write allocate |

## Verification
Two pairs of functions can collide in one cycle. The first is a fill completing while a write is compared against the stored page. The second is a settings load arriving together with a request. The bench drives `fill_done` and `wr_req` in the same cycle, with the fill pointing at the very page being written. It expects a refusal for that write and an allocation for the identical write one cycle later. The settings collision is provoked the same way: it must refuse first and allocate after.

// File: rtl/wa_pkg.sv
// Package: shared constants and the vote record for the write-allocate unit.
// Assumes byte addresses of WA_ADDR_W bits and a 4 KB page.
package wa_pkg;
    localparam int WA_ADDR_W     = 32;
    localparam int WA_PAGE_SHIFT = 12;
    localparam int WA_LIMIT_W    = 7;
    localparam int WA_LIMIT_SHIFT = 22;   // 4 MB granules
    localparam int WA_WIN_SHIFT  = 20;    // 1 MB window granule
    localparam int WA_WIN_BLOCK  = 15;    // window starts at 15 MB

    // One bit per cacheability hint
    typedef struct packed {
        logic page_hit;
        logic sector_hit;
        logic limit_hit;
        logic window_hit;
    } wa_votes_t;
endpackage

// File: rtl/wa_page_track.sv
// Module: remembers the page of the latest completed line fill and
// compares a write address against it. The compare uses the value held
// before a same-cycle update. Assumes PAGE_SHIFT < ADDR_W.
module wa_page_track #(
    parameter int ADDR_W     = 32,
    parameter int PAGE_SHIFT = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fill_done,
    input  logic [ADDR_W-1:0] fill_addr,
    input  logic [ADDR_W-1:0] chk_addr,
    output logic              page_hit,
    output logic              page_vld_o,
    output logic [ADDR_W-PAGE_SHIFT-1:0] page_o
);
    localparam int PG_W = ADDR_W - PAGE_SHIFT;

    logic            vld_q;
    logic [PG_W-1:0] page_q;

    // Capture the page of each finished fill; invalid until the first one
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_q  <= 1'b0;
            page_q <= '0;
        end else if (fill_done) begin
            vld_q  <= 1'b1;
            page_q <= fill_addr[ADDR_W-1:PAGE_SHIFT];
        end
    end

    // Compare the write page with the page held before any update
    always_comb begin
        page_hit = vld_q && (chk_addr[ADDR_W-1:PAGE_SHIFT] == page_q);
    end

    assign page_vld_o = vld_q;
    assign page_o     = page_q;
endmodule

// File: rtl/wa_region_cfg.sv
// Module: holds the write-handling settings (limit in coarse granules and
// the fixed window enable) and tests a write address against both regions.
// Assumes LIMIT_W <= ADDR_W - LIMIT_SHIFT.
module wa_region_cfg #(
    parameter int ADDR_W      = 32,
    parameter int LIMIT_W     = 7,
    parameter int LIMIT_SHIFT = 22,
    parameter int WIN_SHIFT   = 20,
    parameter int WIN_BLOCK   = 15
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_we,
    input  logic [LIMIT_W-1:0] cfg_limit,
    input  logic               cfg_win_en,
    input  logic [ADDR_W-1:0]  chk_addr,
    output logic               limit_hit,
    output logic               window_hit,
    output logic [LIMIT_W-1:0] limit_o,
    output logic               win_en_o
);
    localparam int UP_W  = ADDR_W - LIMIT_SHIFT;
    localparam int WIN_W = ADDR_W - WIN_SHIFT;
    localparam logic [WIN_W-1:0] WIN_TAG = WIN_W'(WIN_BLOCK);

    logic [LIMIT_W-1:0] limit_q;
    logic               win_q;

    // Load the settings on a register write; both start disabled
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            limit_q <= '0;
            win_q   <= 1'b0;
        end else if (cfg_we) begin
            limit_q <= cfg_limit;
            win_q   <= cfg_win_en;
        end
    end

    // Region tests against the settings currently held
    always_comb begin
        limit_hit  = (limit_q != '0) &&
                     (chk_addr[ADDR_W-1:LIMIT_SHIFT] < UP_W'(limit_q));
        window_hit = win_q && (chk_addr[ADDR_W-1:WIN_SHIFT] == WIN_TAG);
    end

    assign limit_o  = limit_q;
    assign win_en_o = win_q;
endmodule

// File: rtl/wa_vote_merge.sv
// Module: merges the cacheability hints into one allocate vote.
// NV selects how many leading bits of the vote record take part.
module wa_vote_merge
    import wa_pkg::*;
#(
    parameter int NV = 4
) (
    input  wa_votes_t votes,
    output logic      take
);
    logic [NV-1:0] flat;

    // Flatten the record so the OR width follows the parameter
    generate
        for (genvar i = 0; i < NV; i++) begin : g_flat
            assign flat[i] = votes[$bits(wa_votes_t)-1-i];
        end
    endgenerate

    // Any single hint is enough to allocate
    always_comb begin
        take = |flat;
    end
endmodule

// File: rtl/wa_decide_unit.sv
// Module: top of the write-allocate decision unit. Gathers the hints for
// each write miss and registers the decision with a one-cycle strobe.
// Assumes the cache lookup presents sector and line status with wr_req.
module wa_decide_unit
    import wa_pkg::*;
#(
    parameter int ADDR_W      = WA_ADDR_W,
    parameter int PAGE_SHIFT  = WA_PAGE_SHIFT,
    parameter int LIMIT_W     = WA_LIMIT_W,
    parameter int LIMIT_SHIFT = WA_LIMIT_SHIFT
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_req,
    input  logic [ADDR_W-1:0]  wr_addr,
    input  logic               sec_tag_hit,
    input  logic               line_valid,
    input  logic               fill_done,
    input  logic [ADDR_W-1:0]  fill_addr,
    input  logic               cfg_we,
    input  logic [LIMIT_W-1:0] cfg_limit,
    input  logic               cfg_win_en,
    output logic               alloc_valid,
    output logic               alloc_take
);
    localparam int PG_W = ADDR_W - PAGE_SHIFT;

    wa_votes_t          votes;
    logic               take_c;
    logic               page_vld;
    logic [PG_W-1:0]    page_q;
    logic [LIMIT_W-1:0] lim_q;
    logic               win_q;
    logic               vld_q;
    logic               take_q;

    wa_page_track #(.ADDR_W(ADDR_W), .PAGE_SHIFT(PAGE_SHIFT)) u_page (
        .clk(clk), .rst_n(rst_n),
        .fill_done(fill_done), .fill_addr(fill_addr),
        .chk_addr(wr_addr), .page_hit(votes.page_hit),
        .page_vld_o(page_vld), .page_o(page_q)
    );

    wa_region_cfg #(
        .ADDR_W(ADDR_W), .LIMIT_W(LIMIT_W), .LIMIT_SHIFT(LIMIT_SHIFT),
        .WIN_SHIFT(WA_WIN_SHIFT), .WIN_BLOCK(WA_WIN_BLOCK)
    ) u_region (
        .clk(clk), .rst_n(rst_n),
        .cfg_we(cfg_we), .cfg_limit(cfg_limit), .cfg_win_en(cfg_win_en),
        .chk_addr(wr_addr),
        .limit_hit(votes.limit_hit), .window_hit(votes.window_hit),
        .limit_o(lim_q), .win_en_o(win_q)
    );

    // Sector present but addressed line absent: the page is known cacheable
    always_comb begin
        votes.sector_hit = sec_tag_hit && !line_valid;
    end

    wa_vote_merge #(.NV(4)) u_merge (.votes(votes), .take(take_c));

    // Register the decision and its strobe one cycle after the request
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_q  <= 1'b0;
            take_q <= 1'b0;
        end else begin
            vld_q  <= wr_req;
            take_q <= wr_req && take_c;
        end
    end

    assign alloc_valid = vld_q;
    assign alloc_take  = take_q;
endmodule

// File: rtl/wa_decide_chk.sv
// Module: property checker for wa_decide_unit, attached by bind below.
module wa_decide_chk #(
    parameter int ADDR_W      = 32,
    parameter int PAGE_SHIFT  = 12,
    parameter int LIMIT_W     = 7,
    parameter int LIMIT_SHIFT = 22
) (
    input logic               clk,
    input logic               rst_n,
    input logic               wr_req,
    input logic [ADDR_W-1:0]  wr_addr,
    input logic               sec_tag_hit,
    input logic               line_valid,
    input logic               fill_done,
    input logic [ADDR_W-1:0]  fill_addr,
    input logic               cfg_we,
    input logic               alloc_valid,
    input logic               alloc_take,
    input logic               page_vld,
    input logic [ADDR_W-PAGE_SHIFT-1:0] page_q,
    input logic [LIMIT_W-1:0] lim_q,
    input logic               win_q
);
    localparam int UP_W = ADDR_W - LIMIT_SHIFT;

    logic pg_m, sec_m, lim_m, win_m;
    assign pg_m  = page_vld && (wr_addr[ADDR_W-1:PAGE_SHIFT] == page_q);
    assign sec_m = sec_tag_hit && !line_valid;
    assign lim_m = (lim_q != '0) && (wr_addr[ADDR_W-1:LIMIT_SHIFT] < UP_W'(lim_q));
    assign win_m = win_q && (wr_addr[ADDR_W-1:20] == 12'h00F);

    a_r2_strobe_follows: assert property (@(posedge clk) disable iff (!rst_n)
        wr_req |=> alloc_valid);
    a_r2_no_stray_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_req |=> !alloc_valid);
    a_r2_take_gated: assert property (@(posedge clk) disable iff (!rst_n)
        alloc_take |-> alloc_valid);
    a_r3_page_vote: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_req && pg_m) |=> alloc_take);
    a_r4_fill_stored: assert property (@(posedge clk) disable iff (!rst_n)
        fill_done |=> (page_vld && page_q == $past(fill_addr[ADDR_W-1:PAGE_SHIFT])));
    a_r6_sector_vote: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_req && sec_m) |=> alloc_take);
    a_r7_limit_vote: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_req && lim_m) |=> alloc_take);
    a_r8_window_vote: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_req && win_m) |=> alloc_take);
    a_r9_no_vote: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_req && !pg_m && !sec_m && !lim_m && !win_m) |=> !alloc_take);
    a_r10_cfg_held: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_we |=> ($stable(lim_q) && $stable(win_q)));
endmodule

bind wa_decide_unit wa_decide_chk #(
    .ADDR_W(ADDR_W), .PAGE_SHIFT(PAGE_SHIFT),
    .LIMIT_W(LIMIT_W), .LIMIT_SHIFT(LIMIT_SHIFT)
) u_chk (
    .clk(clk), .rst_n(rst_n), .wr_req(wr_req), .wr_addr(wr_addr),
    .sec_tag_hit(sec_tag_hit), .line_valid(line_valid),
    .fill_done(fill_done), .fill_addr(fill_addr), .cfg_we(cfg_we),
    .alloc_valid(alloc_valid), .alloc_take(alloc_take),
    .page_vld(page_vld), .page_q(page_q), .lim_q(lim_q), .win_q(win_q)
);

// File: tb/sim_wa_decide_unit.sv
`timescale 1ns/1ps
module sim_wa_decide_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_req = 1'b0;
    logic [31:0] wr_addr = '0;
    logic        sec_tag_hit = 1'b0;
    logic        line_valid = 1'b0;
    logic        fill_done = 1'b0;
    logic [31:0] fill_addr = '0;
    logic        cfg_we = 1'b0;
    logic [6:0]  cfg_limit = '0;
    logic        cfg_win_en = 1'b0;
    logic        alloc_valid;
    logic        alloc_take;

    int checks = 0;
    int errors = 0;
    bit    exp_q[$];
    string req_q[$];
    bit    done = 1'b0;

    always #2 clk = ~clk;

    wa_decide_unit u0 (
        .clk(clk), .rst_n(rst_n), .wr_req(wr_req), .wr_addr(wr_addr),
        .sec_tag_hit(sec_tag_hit), .line_valid(line_valid),
        .fill_done(fill_done), .fill_addr(fill_addr),
        .cfg_we(cfg_we), .cfg_limit(cfg_limit), .cfg_win_en(cfg_win_en),
        .alloc_valid(alloc_valid), .alloc_take(alloc_take)
    );

    // Driver: one write miss per call, with optional same-cycle fill or settings load
    task automatic wr(input logic [31:0] a, input bit tag, input bit lv,
                      input bit exp, input string req,
                      input bit fl = 0, input logic [31:0] fa = '0,
                      input bit cw = 0, input logic [6:0] cl = '0, input bit ce = 0);
        wr_req = 1'b1; wr_addr = a; sec_tag_hit = tag; line_valid = lv;
        fill_done = fl; fill_addr = fa;
        cfg_we = cw; cfg_limit = cl; cfg_win_en = ce;
        exp_q.push_back(exp); req_q.push_back(req);
        @(negedge clk);
        wr_req = 1'b0; sec_tag_hit = 1'b0; line_valid = 1'b0;
        fill_done = 1'b0; cfg_we = 1'b0;
    endtask

    task automatic fill(input logic [31:0] a);
        fill_done = 1'b1; fill_addr = a;
        @(negedge clk);
        fill_done = 1'b0;
    endtask

    task automatic cfg(input logic [6:0] l, input bit w);
        cfg_we = 1'b1; cfg_limit = l; cfg_win_en = w;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    // Monitor: pops one expectation per strobe, flags strobes nobody asked for
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n) begin
                if (alloc_valid) begin
                    checks++;
                    if (exp_q.size() == 0) begin
                        errors++;
                        $display("FAIL R2 strobe without request: actual valid=1 expected valid=0");
                    end else begin
                        automatic bit    e = exp_q.pop_front();
                        automatic string r = req_q.pop_front();
                        if (alloc_take !== e) begin
                            errors++;
                            $display("FAIL %s addr-check: actual take=%0b expected take=%0b", r, alloc_take, e);
                        end
                    end
                end else if (alloc_take) begin
                    checks++; errors++;
                    $display("FAIL R2 take without strobe: actual take=1 expected take=0");
                end
            end
        end
    end

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        checks++;
        if (alloc_valid !== 1'b0 || alloc_take !== 1'b0) begin
            errors++;
            $display("FAIL R1 reset outputs: actual %0b%0b expected 00", alloc_valid, alloc_take);
        end
        wr(32'h1234_5678, 0, 0, 0, "R1");
        // R3: page remembered from fill
        fill(32'h1234_5000);
        wr(32'h1234_5FFC, 0, 0, 1, "R3");
        wr(32'h1234_6000, 0, 0, 0, "R3");
        // R4: new page replaces old one (back-to-back requests)
        fill(32'h0ABC_D040);
        wr(32'h1234_5678, 0, 0, 0, "R4");
        wr(32'h0ABC_D800, 0, 0, 1, "R4");
        // R5: same-cycle fill uses the old page
        wr(32'h5555_5010, 0, 0, 0, "R5", 1, 32'h5555_5000);
        wr(32'h5555_5010, 0, 0, 1, "R5");
        // R6: sector hit with line miss
        wr(32'h2000_0000, 1, 0, 1, "R6");
        wr(32'h2000_0000, 1, 1, 0, "R6");
        wr(32'h2000_0000, 0, 0, 0, "R6");
        // R7: limit of 3 x 4 MB = 0x00C00000
        cfg(7'd3, 0);
        wr(32'h00BF_FFFC, 0, 0, 1, "R7");
        wr(32'h00C0_0000, 0, 0, 0, "R7");
        wr(32'h0000_0000, 0, 0, 1, "R7");
        cfg(7'd0, 0);
        wr(32'h0000_0000, 0, 0, 0, "R7");
        // R8: 15-16 MB window
        cfg(7'd0, 1);
        wr(32'h00F0_0000, 0, 0, 1, "R8");
        wr(32'h00FF_FFFF, 0, 0, 1, "R8");
        wr(32'h00EF_FFFF, 0, 0, 0, "R8");
        wr(32'h0100_0000, 0, 0, 0, "R8");
        wr(32'h10F0_0000, 0, 0, 0, "R8");
        cfg(7'd0, 0);
        wr(32'h00F0_0000, 0, 0, 0, "R8");
        // R10: settings load in the same cycle as a request
        wr(32'h00F0_0000, 0, 0, 0, "R10", 0, '0, 1, 7'd0, 1);
        wr(32'h00F0_0000, 0, 0, 1, "R10");
        // R9: OR of hints
        cfg(7'd127, 1);
        wr(32'h00F0_0000, 0, 0, 1, "R9");
        wr(32'h5555_5000, 0, 0, 1, "R9");
        wr(32'h7000_0000, 1, 0, 1, "R9");
        wr(32'h7000_0000, 0, 0, 0, "R9");
        repeat (4) @(negedge clk);
        checks++;
        if (exp_q.size() != 0) begin
            errors++;
            $display("FAIL R2 missing strobes: actual pending=%0d expected 0", exp_q.size());
        end
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule